// File: doc/BRIEF.md
# Prescaled Coincidence Trigger Unit

This block turns six discriminated detector signals (cosmic, trigger clock, S0, S1, S2M, Cherenkov) into one event-trigger pulse. Each input is brought into the clock domain and its rising edge opens a gate of programmable length, counted in 5 ns steps at a 200 MHz clock. Pairs of detectors form coincidence hits when one rises while the gate of the other is still open. A special path accepts S2M without a Cherenkov signal. The cosmic and trigger-clock inputs each form a single-input path. A synchronous software trigger input forms one more path that has no prescaler.

Each of the nine prescaled paths has a 4-bit logarithmic prescale code. Only the hits that the divider lets through can start an event. A small event state machine has three states. In ARMED it accepts triggers. In FIRED it drives the one-cycle event pulse. In BLOCKED it waits while readout holds busy high. The transitions are as follows. ARMED goes to FIRED on any surviving trigger and to BLOCKED while busy is high. FIRED goes to BLOCKED if busy is high and otherwise to ARMED. BLOCKED goes back to ARMED once busy is low.

On entry to FIRED the unit latches a 17-bit pattern word. The low bits record which inputs were active. The upper bits record every path that caused the event.

Top module: `coinc_trig_unit`

## Requirements
- R1: After reset, evt_trig is 0, pattern is 0, the gate width is 14, and every prescale code is 0. So with no configuration written, no input causes an event.
- R2: A write with cfg_we high stores cfg_data[3:0] as the prescale code of a channel. The channel is chosen by cfg_addr: 0 clock, 1 cosmic, 2 S2M-without-Cherenkov, 3 S0&S1, 4 S0&S2M, 5 S0&Cherenkov, 6 S1&S2M, 7 S1&Cherenkov, 8 S2M&Cherenkov. cfg_addr 9 stores cfg_data[7:0] as the gate width. Writes to addresses 10 to 15 change nothing.
- R3: Prescale code 0 disables its path, so that path never causes an event.
- R4: Code 1 passes every qualified hit. Code k, for k from 2 to 15, passes only the 2^(k-1)-th qualified hit of each run, for example every 4th hit for code 3.
- R5: Writing a channel's code restarts its hit count from zero.
- R6: A pair coincidence occurs when the two inputs rise in the same cycle, or when the second rises 1 to W cycles after the first, where W is the gate width. The order of the two inputs does not matter. A separation of W+1 cycles gives no coincidence.
- R7: A new gate width written at address 9 takes effect for the coincidences that follow.
- R8: An event is a single-cycle pulse on evt_trig. It starts two clocks after a raw input changes, or one clock after vme_trig. Pattern bits 16..6 mark the cause: 16 clock, 15 cosmic, 14 software trigger, 13 S0&S1, 12 S0&S2M, 11 S0&Cherenkov, 10 S1&S2M, 9 S1&Cherenkov, 8 S2M&Cherenkov, 7 always 0, 6 S2M-without-Cherenkov.
- R9: Pattern bits 5..0 are the raw status bits: 0 cosmic, 1 clock, 2 S0, 3 S1, 4 S2M, 5 Cherenkov. A bit is 1 if that input rose in the firing cycle or its gate is still open, even when its path did not cause the event.
- R10: When several paths fire in the same cycle, all of their cause bits are set.
- R11: While busy is high, no event is issued and no prescale count advances.
- R12: The S2M-without-Cherenkov path fires on a rising S2M only if Cherenkov is neither rising nor inside its gate.
- R13: A one-cycle vme_trig pulse in ARMED state causes an event with pattern bit 14 set.
- R14: The pattern word keeps its value until the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz clock, one gate step per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_in | input | 6 | Discriminated detector levels |
| vme_trig | input | 1 | Synchronous software trigger pulse |
| busy | input | 1 | Readout in progress; blocks triggers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_data | input | 8 | Configuration write data |
| evt_trig | output | 1 | One-cycle event trigger |
| pattern | output | 17 | Latched trigger pattern word |

## Verification
A prescale counter in the wrong state shows up as an event one or more hits too early or too late. The bench therefore counts events across runs of hits, including a run that spans a code rewrite, to catch a count that did not clear. A gate counter that is off by one shows up only at the window edges, so coincidences are tried at exactly W and W+1 cycles of separation, in both orders, and with two gate widths. A wrong event-state value shows up within a few cycles: as a pulse longer than one cycle, as an event while busy is high, or as a pattern word that changes with no pulse.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
    localparam int NRAW   = 6;
    localparam int NCH    = 9;
    localparam int PAT_W  = 17;
    localparam int CODE_W = 4;
    localparam int CFG_AW = 4;
    localparam int CFG_DW = 8;

    localparam int IN_COSMIC = 0;
    localparam int IN_CLK    = 1;
    localparam int IN_S0     = 2;
    localparam int IN_S1     = 3;
    localparam int IN_S2M    = 4;
    localparam int IN_CER    = 5;

    localparam int ADDR_GATE = 9;
    localparam int BIT_VME   = 14;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_FIRED   = 2'd1,
        ST_BLOCKED = 2'd2
    } ev_state_t;

    // pattern bit that records each prescale channel as a cause
    function automatic int cause_bit(input int ch);
        case (ch)
            0:       return 16;
            1:       return 15;
            2:       return 6;
            3:       return 13;
            4:       return 12;
            5:       return 11;
            6:       return 10;
            7:       return 9;
            default: return 8;
        endcase
    endfunction
endpackage

// File: rtl/ctu_edge_gate.sv
module ctu_edge_gate #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw,
    input  logic [GW-1:0] gate_w,
    output logic          rise,
    output logic          active
);
    logic          sync_q;
    logic          prev_q;
    logic [GW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            prev_q <= 1'b0;
            left_q <= '0;
        end else begin
            sync_q <= raw;
            prev_q <= sync_q;
            if (rise)
                left_q <= gate_w;
            else if (left_q != '0)
                left_q <= left_q - GW'(1);
        end
    end

    assign rise   = sync_q & ~prev_q;
    assign active = rise | (left_q != '0);

    // R6: an edge with a nonzero width keeps the input active one cycle later
    a_r6_gate_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && gate_w != '0) |=> active);
endmodule

// File: rtl/ctu_prescaler.sv
module ctu_prescaler #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_we,
    input  logic [CODE_W-1:0] code_wdata,
    input  logic              hit,
    output logic              pass
);
    localparam int CNT_W = (1 << CODE_W) - 2;

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  limit;
    logic              enabled;

    assign enabled = (code_q != '0);
    assign limit   = ~({CNT_W{1'b1}} << (code_q - CODE_W'(1)));
    assign pass    = hit & enabled & (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            cnt_q  <= '0;
        end else if (code_we) begin
            code_q <= code_wdata;
            cnt_q  <= '0;
        end else if (hit && enabled) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R4: the count never passes the reload point of the active code
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |-> cnt_q <= limit);
    // R5: a code write leaves the count at zero
    a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        code_we |=> cnt_q == '0);
endmodule

// File: rtl/coinc_trig_unit.sv
module coinc_trig_unit
    import ctu_pkg::*;
#(
    parameter int GATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRAW-1:0]   raw_in,
    input  logic              vme_trig,
    input  logic              busy,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_data,
    output logic              evt_trig,
    output logic [PAT_W-1:0]  pattern
);
    localparam logic [GATE_W-1:0] GATE_RST = GATE_W'(14);

    logic [GATE_W-1:0] gate_q;
    logic [NRAW-1:0]   rise;
    logic [NRAW-1:0]   act;
    logic [NCH-1:0]    hit;
    logic [NCH-1:0]    pass;
    logic [PAT_W-1:0]  cause;
    logic              qualify;
    logic              fire_any;
    ev_state_t         state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= GATE_RST;
        else if (cfg_we && cfg_addr == CFG_AW'(ADDR_GATE))
            gate_q <= cfg_data[GATE_W-1:0];
    end

    for (genvar g = 0; g < NRAW; g++) begin : g_in
        ctu_edge_gate #(.GW(GATE_W)) u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (raw_in[g]),
            .gate_w (gate_q),
            .rise   (rise[g]),
            .active (act[g])
        );
    end

    function automatic logic pair_hit(input int a, input int b,
                                      input logic [NRAW-1:0] r,
                                      input logic [NRAW-1:0] ac);
        return (r[a] & ac[b]) | (r[b] & ac[a]);
    endfunction

    always_comb begin
        hit[0] = rise[IN_CLK];
        hit[1] = rise[IN_COSMIC];
        hit[2] = rise[IN_S2M] & ~act[IN_CER];
        hit[3] = pair_hit(IN_S0,  IN_S1,  rise, act);
        hit[4] = pair_hit(IN_S0,  IN_S2M, rise, act);
        hit[5] = pair_hit(IN_S0,  IN_CER, rise, act);
        hit[6] = pair_hit(IN_S1,  IN_S2M, rise, act);
        hit[7] = pair_hit(IN_S1,  IN_CER, rise, act);
        hit[8] = pair_hit(IN_S2M, IN_CER, rise, act);
    end

    assign qualify = (state_q == ST_ARMED) & ~busy;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ctu_prescaler #(.CODE_W(CODE_W)) u_ps (
            .clk        (clk),
            .rst_n      (rst_n),
            .code_we    (cfg_we && cfg_addr == CFG_AW'(c)),
            .code_wdata (cfg_data[CODE_W-1:0]),
            .hit        (hit[c] & qualify),
            .pass       (pass[c])
        );
    end

    always_comb begin
        cause = '0;
        cause[NRAW-1:0] = act;
        for (int c = 0; c < NCH; c++)
            cause[cause_bit(c)] = pass[c];
        cause[BIT_VME] = vme_trig & qualify;
    end

    assign fire_any = (|pass) | (vme_trig & qualify);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:   if (busy) state_d = ST_BLOCKED;
                        else if (fire_any) state_d = ST_FIRED;
            ST_FIRED:   state_d = busy ? ST_BLOCKED : ST_ARMED;
            ST_BLOCKED: if (!busy) state_d = ST_ARMED;
            default:    state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            pattern <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ARMED && state_d == ST_FIRED)
                pattern <= cause;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FIRED: evt_trig = 1'b1;
            default:  evt_trig = 1'b0;
        endcase
    end

    // R8: the event pulse lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_trig |=> !evt_trig);
    // R8: every event names at least one cause
    a_r8_cause_named: assert property (@(posedge clk) disable iff (!rst_n)
        evt_trig |-> (|pattern[PAT_W-1:NRAW]));
    // R11: no event follows a cycle with busy high
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        evt_trig |-> !$past(busy));
    // R14: the pattern word only changes together with an event
    a_r14_pattern_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pattern) |-> evt_trig);
endmodule

// File: tb/sim_coinc_trig_unit.sv
module sim_coinc_trig_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  raw_in = '0;
    logic        vme_trig = 1'b0;
    logic        busy = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_data = '0;
    logic        evt_trig;
    logic [16:0] pattern;

    int checks = 0;
    int errors = 0;
    int ev_cnt = 0;
    logic [16:0] last_pat = '0;
    bit done = 1'b0;

    localparam logic [5:0] M_COS = 6'h01, M_CLK = 6'h02, M_S0 = 6'h04,
                           M_S1 = 6'h08, M_S2M = 6'h10, M_CER = 6'h20;

    always #5 clk = ~clk;

    coinc_trig_unit u0 (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .vme_trig(vme_trig),
        .busy(busy), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .evt_trig(evt_trig), .pattern(pattern)
    );

    always @(negedge clk) begin
        if (evt_trig) begin
            ev_cnt   = ev_cnt + 1;
            last_pat = pattern;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_codes();
        for (int i = 0; i < 9; i++) wr(4'(i), 8'd0);
    endtask

    task automatic pulse(input logic [5:0] m);
        @(negedge clk); raw_in = raw_in | m;
        @(negedge clk); raw_in = raw_in & ~m;
    endtask

    // second input rises d cycles (d >= 2) after the first
    task automatic coinc(input logic [5:0] a, input logic [5:0] b, input int d);
        pulse(a);
        idle(d - 2);
        pulse(b);
        idle(40);
    endtask

    task automatic t_reset();
        chk("R1 evt_trig after reset", 32'(evt_trig), 0);
        chk("R1 pattern after reset", 32'(pattern), 0);
        pulse(M_CLK); pulse(M_COS); idle(10);
        chk("R1 codes zero, no event", ev_cnt, 0);
    endtask

    task automatic t_clock_path();
        int e0;
        clear_codes(); wr(4'd0, 8'd1);
        e0 = ev_cnt;
        pulse(M_CLK); idle(10);
        chk("R8 clock event count", ev_cnt - e0, 1);
        chk("R8 R9 clock pattern", 32'(last_pat), 32'h10002);
        wr(4'd15, 8'd0); wr(4'd12, 8'd0);
        e0 = ev_cnt;
        pulse(M_CLK); idle(10);
        chk("R2 unmapped writes ignored", ev_cnt - e0, 1);
        wr(4'd0, 8'd0);
        e0 = ev_cnt;
        pulse(M_CLK); idle(10);
        chk("R3 code 0 disables", ev_cnt - e0, 0);
    endtask

    task automatic t_prescale();
        int e0;
        clear_codes(); wr(4'd1, 8'd3);
        e0 = ev_cnt;
        for (int i = 0; i < 3; i++) begin pulse(M_COS); idle(4); end
        chk("R4 no event before 4th hit", ev_cnt - e0, 0);
        pulse(M_COS); idle(4);
        chk("R4 event on 4th hit", ev_cnt - e0, 1);
        chk("R4 cosmic pattern", 32'(last_pat), 32'h08001);
        for (int i = 0; i < 4; i++) begin pulse(M_COS); idle(4); end
        chk("R4 second run of 4", ev_cnt - e0, 2);
        e0 = ev_cnt;
        for (int i = 0; i < 3; i++) begin pulse(M_COS); idle(4); end
        wr(4'd1, 8'd3);
        for (int i = 0; i < 3; i++) begin pulse(M_COS); idle(4); end
        chk("R5 rewrite restarts count", ev_cnt - e0, 0);
        pulse(M_COS); idle(4);
        chk("R5 event after fresh 4", ev_cnt - e0, 1);
    endtask

    task automatic t_window();
        int e0;
        clear_codes(); wr(4'd4, 8'd1);
        e0 = ev_cnt;
        coinc(M_S0, M_S2M, 14);
        chk("R6 hit at W=14", ev_cnt - e0, 1);
        chk("R6 R9 S0&S2M pattern", 32'(last_pat), 32'h01014);
        coinc(M_S0, M_S2M, 15);
        chk("R6 miss at W+1", ev_cnt - e0, 1);
        coinc(M_S2M, M_S0, 14);
        chk("R6 reversed order hit", ev_cnt - e0, 2);
        pulse(M_S0 | M_S2M); idle(40);
        chk("R6 same-cycle rise hit", ev_cnt - e0, 3);
        wr(4'd9, 8'd3);
        coinc(M_S0, M_S2M, 3);
        chk("R7 hit at W=3", ev_cnt - e0, 4);
        coinc(M_S0, M_S2M, 4);
        chk("R7 miss at W+1=4", ev_cnt - e0, 4);
        wr(4'd9, 8'd14);
    endtask

    task automatic t_multi();
        int e0;
        clear_codes(); wr(4'd3, 8'd1); wr(4'd4, 8'd1);
        e0 = ev_cnt;
        coinc(M_S1 | M_S2M, M_S0, 3);
        chk("R10 one event", ev_cnt - e0, 1);
        chk("R10 both causes", 32'(last_pat), 32'h0301C);
    endtask

    task automatic t_s2m_ncer();
        int e0;
        clear_codes(); wr(4'd2, 8'd1);
        e0 = ev_cnt;
        pulse(M_S2M); idle(10);
        chk("R12 S2M alone fires", ev_cnt - e0, 1);
        chk("R12 pattern", 32'(last_pat), 32'h00050);
        coinc(M_CER, M_S2M, 5);
        chk("R12 vetoed by Cherenkov", ev_cnt - e0, 1);
    endtask

    task automatic t_busy();
        int e0;
        logic [16:0] p0;
        clear_codes(); wr(4'd0, 8'd1); wr(4'd1, 8'd2);
        p0 = pattern;
        e0 = ev_cnt;
        @(negedge clk); busy = 1'b1;
        pulse(M_CLK); idle(6);
        chk("R11 no event while busy", ev_cnt - e0, 0);
        chk("R14 pattern kept while busy", 32'(pattern), 32'(p0));
        pulse(M_COS); idle(4);
        busy = 1'b0; idle(4);
        pulse(M_COS); idle(6);
        chk("R11 busy hit not counted", ev_cnt - e0, 0);
        pulse(M_COS); idle(6);
        chk("R11 counts after busy", ev_cnt - e0, 1);
    endtask

    task automatic t_vme();
        int e0;
        clear_codes();
        e0 = ev_cnt;
        @(negedge clk); vme_trig = 1'b1;
        @(negedge clk); vme_trig = 1'b0;
        chk("R13 vme event in one clock", 32'(evt_trig), 1);
        idle(4);
        chk("R13 vme event count", ev_cnt - e0, 1);
        chk("R13 vme pattern", 32'(last_pat), 32'h04000);
        idle(20);
        chk("R14 pattern held", 32'(pattern), 32'h04000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clock_path();
        t_prescale();
        t_window();
        t_multi();
        t_s2m_ncer();
        t_busy();
        t_vme();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule